// File: doc/BRIEF.md
# Two-Wire Bus Byte Master with Step Status Codes

This block is a byte-at-a-time master for a two-wire serial bus (I2C). Software drives it through three 8-bit style registers: a control register that holds bus enable, start request, stop request, an event flag and an acknowledge-select bit; a data register that carries the address byte or a data byte; and a read-only status register. Every bus step the engine finishes ends with a numeric status code and the event flag set. While the flag stays set the engine parks with SCL held low. Software writes the flag bit back as 0 to let the next step run.

The first byte after a start or repeated start is an address byte, taken from the data register. Its bit 0 picks the direction of the bytes that follow. A separate interrupt register holds a core interrupt enable and two manual line override bits. Software can use the overrides to clock a stuck device free and to hand-build a stop condition. Both bus lines are open drain: the block only outputs pull-low enables and samples the resolved line levels.

Bus timing is derived from a quarter-bit tick. The tick comes from a prescaler parameter `QDIV`, counted in clock cycles. Every bus bit uses four ticks: set SDA, release SCL, sample, pull SCL low.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register reads 0x00, the data register 0x00, the status register 0xF8 (idle) and the interrupt register 0x000. Both line enables are low and the interrupt output is low.
- R2: The control register bit positions are: bit 6 bus enable, bit 5 start request, bit 4 stop request, bit 3 event flag, bit 2 acknowledge select. A write of bit 6 and bit 5 on an idle bus produces a start condition, with SDA falling while SCL is high. The status then becomes 0x08, bit 3 is set and hardware clears bit 5.
- R3: While bit 3 is set, the engine holds SCL low and takes no further bus step. A control write with bit 3 at 0 clears the flag and lets the engine continue. A write with bit 3 at 1 leaves the flag as it was.
- R4: The byte sent after a start is the data register, MSB first. Its bit 0 selects read (1) or write (0). The resulting status is 0x18 for a write address that is acknowledged, 0x20 for one that is not, 0x40 for a read address that is acknowledged and 0x48 for one that is not. The status register only ever shows 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x40, 0x48, 0x50, 0x58 or 0xF8.
- R5: In write direction each later step sends the data register MSB first. The status becomes 0x28 when the device acknowledges and 0x30 when it does not.
- R6: In read direction each later step shifts in one byte, MSB first, and stores it in the data register. The engine returns ACK (SDA low) when bit 2 is set and the status becomes 0x50. It returns NACK when bit 2 is clear and the status becomes 0x58.
- R7: Clearing the flag with bit 5 set while the engine is parked produces a repeated start and status 0x10. The next byte is again treated as an address.
- R8: Clearing the flag with bit 4 set while the engine is parked produces a stop condition, with SDA rising while SCL is high. Afterwards the status is 0xF8, bit 4 is cleared by hardware and the event flag stays clear.
- R9: A start request on an idle bus waits as long as SDA is held low by another device. During the wait the status stays 0xF8, the flag stays clear and the block pulls neither line.
- R10: Interrupt register bit 6 is the core interrupt enable. The interrupt output is high exactly while that bit is set and the status is not 0xF8.
- R11: Interrupt register bit 9 forces SCL low and bit 8 forces SDA low, whatever the engine is doing. Clearing them hands the lines back to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 interrupt |
| reg_wdata | input | 10 | Write data (bits 7:0 for control and data, bits 9:0 for interrupt) |
| ctl_rd | output | 8 | Control register contents |
| data_rd | output | 8 | Data register contents |
| status_rd | output | 8 | Status code |
| intr_rd | output | 10 | Interrupt register contents |
| irq | output | 1 | Core interrupt |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A wrong step state or phase count shows up on the lines within one bit time, about four ticks. It appears as a missing or extra SCL pulse, or an SDA change while SCL is high. A device model on the bus then logs a wrong byte, or the status code after the ninth clock does not match. A lost or stuck event flag shows as a release of SCL while the flag is set, or as a status step that never arrives. In either case it is visible at the next expected event. A wrong direction or acknowledge latch shows up as the wrong code of a pair (0x50 against 0x58, 0x18 against 0x20) at the end of that same byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_DAT = 2'd1;
    localparam logic [1:0] SEL_INT = 2'd2;

    localparam int B_ENAB  = 6;
    localparam int B_STA   = 5;
    localparam int B_STP   = 4;
    localparam int B_FLAG  = 3;
    localparam int B_AAK   = 2;
    localparam int B_IEN   = 6;
    localparam int B_SDAOV = 8;
    localparam int B_SCLOV = 9;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RSTART  = 8'h10;
    localparam logic [7:0] ST_AW_ACK  = 8'h18;
    localparam logic [7:0] ST_AW_NACK = 8'h20;
    localparam logic [7:0] ST_DW_ACK  = 8'h28;
    localparam logic [7:0] ST_DW_NACK = 8'h30;
    localparam logic [7:0] ST_AR_ACK  = 8'h40;
    localparam logic [7:0] ST_AR_NACK = 8'h48;
    localparam logic [7:0] ST_DR_ACK  = 8'h50;
    localparam logic [7:0] ST_DR_NACK = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [2:0] {
        E_IDLE, E_START, E_BYTE, E_ACK, E_HOLD, E_STOP
    } eng_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/i2cm_pads.sv
module i2cm_pads (
    input  logic eng_scl_lo,
    input  logic eng_sda_lo,
    input  logic ovr_scl,
    input  logic ovr_sda,
    output logic scl_oe,
    output logic sda_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        scl_oe = eng_scl_lo | ovr_scl;
        sda_oe = eng_sda_lo | ovr_sda;
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int QDIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [9:0]  reg_wdata,
    output logic [7:0]  ctl_rd,
    output logic [7:0]  data_rd,
    output logic [7:0]  status_rd,
    output logic [9:0]  intr_rd,
    output logic        irq,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        eng_e       st;
        logic [1:0] ph;
        logic [2:0] bitn;
        logic [7:0] sh;
        logic       scl_lo;
        logic       sda_lo;
        logic       enab;
        logic       sta;
        logic       stp;
        logic       iflg;
        logic       aak;
        logic [7:0] data;
        logic [7:0] status;
        logic       ien;
        logic       sda_ovr;
        logic       scl_ovr;
        logic       addr_pend;
        logic       rd_mode;
        logic       tx;
        logic       rs;
        logic       ack;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;

    i2cm_qtick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        r_d = r_q;
        // software register writes
        if (reg_we) begin
            case (reg_sel)
                SEL_CTL: begin
                    r_d.enab = reg_wdata[B_ENAB];
                    r_d.sta  = reg_wdata[B_STA];
                    r_d.stp  = reg_wdata[B_STP];
                    r_d.aak  = reg_wdata[B_AAK];
                    r_d.iflg = r_q.iflg & reg_wdata[B_FLAG];
                end
                SEL_DAT: r_d.data = reg_wdata[7:0];
                SEL_INT: begin
                    r_d.ien     = reg_wdata[B_IEN];
                    r_d.sda_ovr = reg_wdata[B_SDAOV];
                    r_d.scl_ovr = reg_wdata[B_SCLOV];
                end
                default: ;
            endcase
        end
        // bus engine, one phase per quarter-bit tick
        if (tick) begin
            r_d.ph = r_q.ph + 2'd1;
            case (r_q.st)
                E_IDLE: begin
                    r_d.ph = 2'd0;
                    if (r_q.enab && r_q.sta && sda_in && scl_in) begin
                        r_d.st = E_START;
                        r_d.rs = 1'b0;
                    end else if (r_q.stp && !r_q.sta) begin
                        r_d.stp = 1'b0;
                    end
                end
                E_HOLD: begin
                    r_d.ph = 2'd0;
                    if (r_q.enab && !r_q.iflg) begin
                        if (r_q.sta) begin
                            r_d.st = E_START;
                            r_d.rs = 1'b1;
                        end else if (r_q.stp) begin
                            r_d.st = E_STOP;
                        end else begin
                            r_d.st   = E_BYTE;
                            r_d.sh   = r_q.data;
                            r_d.bitn = 3'd7;
                            r_d.tx   = r_q.addr_pend | ~r_q.rd_mode;
                            if (r_q.addr_pend) r_d.rd_mode = r_q.data[0];
                        end
                    end
                end
                E_START: begin
                    case (r_q.ph)
                        2'd0: r_d.sda_lo = 1'b0;
                        2'd1: r_d.scl_lo = 1'b0;
                        2'd2: r_d.sda_lo = 1'b1;
                        default: begin
                            r_d.scl_lo    = 1'b1;
                            r_d.st        = E_HOLD;
                            r_d.status    = r_q.rs ? ST_RSTART : ST_START;
                            r_d.iflg      = 1'b1;
                            r_d.sta       = 1'b0;
                            r_d.addr_pend = 1'b1;
                        end
                    endcase
                end
                E_BYTE: begin
                    case (r_q.ph)
                        2'd0: r_d.sda_lo = r_q.tx & ~r_q.sh[7];
                        2'd1: r_d.scl_lo = 1'b0;
                        2'd2: r_d.sh = {r_q.sh[6:0], sda_in};
                        default: begin
                            r_d.scl_lo = 1'b1;
                            if (r_q.bitn == 3'd0) r_d.st = E_ACK;
                            else                  r_d.bitn = r_q.bitn - 3'd1;
                        end
                    endcase
                end
                E_ACK: begin
                    case (r_q.ph)
                        2'd0: r_d.sda_lo = ~r_q.tx & r_q.aak;
                        2'd1: r_d.scl_lo = 1'b0;
                        2'd2: r_d.ack = ~sda_in;
                        default: begin
                            r_d.scl_lo    = 1'b1;
                            r_d.st        = E_HOLD;
                            r_d.iflg      = 1'b1;
                            r_d.addr_pend = 1'b0;
                            if (r_q.addr_pend) begin
                                if (r_q.rd_mode) r_d.status = r_q.ack ? ST_AR_ACK : ST_AR_NACK;
                                else             r_d.status = r_q.ack ? ST_AW_ACK : ST_AW_NACK;
                            end else if (r_q.rd_mode) begin
                                r_d.status = r_q.aak ? ST_DR_ACK : ST_DR_NACK;
                                r_d.data   = r_q.sh;
                            end else begin
                                r_d.status = r_q.ack ? ST_DW_ACK : ST_DW_NACK;
                            end
                        end
                    endcase
                end
                E_STOP: begin
                    case (r_q.ph)
                        2'd0: r_d.sda_lo = 1'b1;
                        2'd1: r_d.scl_lo = 1'b0;
                        2'd2: r_d.sda_lo = 1'b0;
                        default: begin
                            r_d.st        = E_IDLE;
                            r_d.status    = ST_IDLE;
                            r_d.stp       = 1'b0;
                            r_d.addr_pend = 1'b0;
                            r_d.rd_mode   = 1'b0;
                        end
                    endcase
                end
                default: r_d.st = E_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= E_IDLE;
            r_q.status <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    i2cm_pads u_pads (
        .eng_scl_lo(r_q.scl_lo),
        .eng_sda_lo(r_q.sda_lo),
        .ovr_scl   (r_q.scl_ovr),
        .ovr_sda   (r_q.sda_ovr),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    assign ctl_rd    = {1'b0, r_q.enab, r_q.sta, r_q.stp, r_q.iflg, r_q.aak, 2'b00};
    assign data_rd   = r_q.data;
    assign status_rd = r_q.status;
    assign intr_rd   = {r_q.scl_ovr, r_q.sda_ovr, 1'b0, r_q.ien, 6'b000000};
    assign irq       = r_q.ien & (r_q.status != ST_IDLE);
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       int_wr,
    input logic       flag,
    input logic       sta_bit,
    input logic       stp_bit,
    input logic       scl_ovr,
    input logic       sda_ovr,
    input logic [7:0] status,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_flag_holds_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_oe);

    assert_sta_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sta_bit) && !$past(ctl_wr)) |-> (flag && (status == 8'h08 || status == 8'h10)));

    assert_stp_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stp_bit) && !$past(ctl_wr)) |-> (status == 8'hF8 && !flag));

    assert_scl_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scl_ovr |-> scl_oe);

    assert_sda_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_ovr |-> sda_oe);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flag || $past(int_wr)));

    assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> (status == 8'h08 || status == 8'h10 || status == 8'h18 ||
                              status == 8'h20 || status == 8'h28 || status == 8'h30 ||
                              status == 8'h40 || status == 8'h48 || status == 8'h50 ||
                              status == 8'h58 || status == 8'hF8));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (reg_we && reg_sel == 2'd0),
    .int_wr (reg_we && reg_sel == 2'd2),
    .flag   (ctl_rd[3]),
    .sta_bit(ctl_rd[5]),
    .stp_bit(ctl_rd[4]),
    .scl_ovr(intr_rd[9]),
    .sda_ovr(intr_rd[8]),
    .status (status_rd),
    .irq    (irq),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [9:0] reg_wdata = '0;
    logic [7:0] ctl_rd, data_rd, status_rd;
    logic [9:0] intr_rd;
    logic       irq, scl_oe, sda_oe;
    logic       scl_line, sda_line;
    logic       slv_drv = 1'b0;
    logic       stuck_arm = 1'b0;
    int         stuck_cnt = 0;
    logic       stuck;

    assign stuck    = stuck_arm && (stuck_cnt < 9);
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_drv | stuck);

    i2c_byte_master #(.QDIV(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl_rd(ctl_rd), .data_rd(data_rd),
        .status_rd(status_rd), .intr_rd(intr_rd), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog R2 act=hung exp=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // ---------------- device model on the bus ----------------
    localparam logic [6:0] SLV_ADDR = 7'h50;
    logic       scl_p = 1'b1, sda_p = 1'b1;
    logic       active = 1'b0, first = 1'b0, sel = 1'b0, rdm = 1'b0, sending = 1'b0;
    int         bc = 0;
    int         txi = 0;
    logic [7:0] sh = '0, txb = '0;
    logic [7:0] rx_log[$];

    always @(scl_line or sda_line) begin
        if (scl_line && scl_p && sda_p && !sda_line) begin
            active = 1'b1; bc = 0; first = 1'b1; sel = 1'b0; rdm = 1'b0; slv_drv = 1'b0;
        end else if (scl_line && scl_p && !sda_p && sda_line) begin
            active = 1'b0; slv_drv = 1'b0;
        end else if (scl_line && !scl_p) begin
            if (active) begin
                if (bc < 8) begin
                    sh = {sh[6:0], sda_line};
                    bc++;
                end else if (bc == 9 && sel && rdm) begin
                    sending = !sda_line;
                end
            end
        end else if (!scl_line && scl_p) begin
            if (stuck_arm && stuck_cnt < 9) stuck_cnt++;
            if (active) begin
                if (bc == 8) begin
                    if (first) begin
                        first = 1'b0;
                        sel = (sh[7:1] == SLV_ADDR);
                        rdm = sh[0];
                        slv_drv = sel;
                        sending = sel && sh[0];
                        txi = 0;
                    end else if (sel && !rdm) begin
                        rx_log.push_back(sh);
                        slv_drv = (sh != 8'hFF);
                    end else begin
                        slv_drv = 1'b0;
                    end
                    bc = 9;
                end else if (bc == 9) begin
                    bc = 0;
                    slv_drv = 1'b0;
                    if (sel && rdm && sending) begin
                        txb = (txi == 0) ? 8'hA5 : 8'h3C;
                        txi++;
                        slv_drv = !txb[7];
                    end
                end else if (sel && rdm && sending && bc >= 1 && bc <= 7) begin
                    slv_drv = !txb[7 - bc];
                end
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [7:0] st;
        logic [7:0] dat;
        bit         chkd;
        string      tag;
    } exp_t;
    exp_t exq[$];
    logic flag_p = 1'b0;

    always @(negedge clk) begin
        if (rst_n && ctl_rd[3] && !flag_p) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R3 unexpected event", {24'h0, status_rd}, 32'h0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(status_rd == e.st, e.tag, {24'h0, status_rd}, {24'h0, e.st});
                if (e.chkd) chk(data_rd == e.dat, {e.tag, " data"}, {24'h0, data_rd}, {24'h0, e.dat});
            end
        end
        flag_p = ctl_rd[3];
    end

    task automatic wr(input logic [1:0] s, input logic [9:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic await_flag(input string tag);
        int n = 0;
        while (!ctl_rd[3] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!ctl_rd[3]) chk(1'b0, {tag, " no event"}, 0, 1);
        @(negedge clk);
    endtask

    task automatic step(input logic [9:0] ctl, input logic [7:0] st, input logic [7:0] dat,
                        input bit chkd, input string tag);
        exp_t e;
        e.st = st; e.dat = dat; e.chkd = chkd; e.tag = tag;
        exq.push_back(e);
        wr(2'd0, ctl);
        await_flag(tag);
    endtask

    task automatic do_stop();
        int n = 0;
        wr(2'd0, 10'h050);
        while (ctl_rd[4] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        chk(status_rd == 8'hF8, "R8 status after stop", {24'h0, status_rd}, 32'hF8);
        chk(ctl_rd[3] == 1'b0 && ctl_rd[4] == 1'b0, "R8 flag and stop bit clear", {24'h0, ctl_rd}, 32'h40);
        chk(!scl_oe && !sda_oe, "R8 lines released", {30'h0, scl_oe, sda_oe}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rd == 8'h00 && data_rd == 8'h00, "R1 ctl/data reset", {16'h0, ctl_rd, data_rd}, 0);
        chk(status_rd == 8'hF8, "R1 status reset", {24'h0, status_rd}, 32'hF8);
        chk(intr_rd == 10'h000 && !irq && !scl_oe && !sda_oe, "R1 intr/lines reset",
            {18'h0, intr_rd, irq, scl_oe, sda_oe, 1'b0}, 0);

        wr(2'd2, 10'h040);
        chk(irq == 1'b0, "R10 irq low while idle", {31'h0, irq}, 0);

        // write transfer to the device
        step(10'h060, 8'h08, 8'h00, 1'b0, "R2 start");
        chk(ctl_rd[5] == 1'b0, "R2 start bit cleared", {24'h0, ctl_rd}, 32'h48);
        chk(irq == 1'b1, "R10 irq while busy", {31'h0, irq}, 1);
        wr(2'd1, 10'h0A0);
        step(10'h040, 8'h18, 8'h00, 1'b0, "R4 write address ack");
        repeat (100) @(negedge clk);
        chk(status_rd == 8'h18 && ctl_rd[3] && scl_oe, "R3 parked while flag set",
            {23'h0, scl_oe, status_rd}, 32'h118);
        wr(2'd0, 10'h048);
        repeat (100) @(negedge clk);
        chk(status_rd == 8'h18 && ctl_rd[3], "R3 writing 1 keeps flag",
            {23'h0, ctl_rd[3], status_rd}, 32'h118);
        wr(2'd1, 10'h05A);
        step(10'h040, 8'h28, 8'h00, 1'b0, "R5 data ack");
        wr(2'd1, 10'h0FF);
        step(10'h040, 8'h30, 8'h00, 1'b0, "R5 data nack");
        chk(rx_log.size() == 2, "R5 byte count at device", rx_log.size(), 2);
        if (rx_log.size() == 2) begin
            chk(rx_log[0] == 8'h5A, "R5 first byte MSB first", {24'h0, rx_log[0]}, 32'h5A);
            chk(rx_log[1] == 8'hFF, "R5 second byte", {24'h0, rx_log[1]}, 32'hFF);
        end

        // repeated start, then read
        step(10'h060, 8'h10, 8'h00, 1'b0, "R7 repeated start");
        wr(2'd1, 10'h0A1);
        step(10'h040, 8'h40, 8'h00, 1'b0, "R4 read address ack");
        step(10'h044, 8'h50, 8'hA5, 1'b1, "R6 read with ack");
        step(10'h040, 8'h58, 8'h3C, 1'b1, "R6 read with nack");
        do_stop();
        chk(irq == 1'b0, "R10 irq drops at idle", {31'h0, irq}, 0);

        // absent device
        step(10'h060, 8'h08, 8'h00, 1'b0, "R2 start again");
        wr(2'd1, 10'h044);
        step(10'h040, 8'h20, 8'h00, 1'b0, "R4 write address nack");
        step(10'h060, 8'h10, 8'h00, 1'b0, "R7 repeated start again");
        wr(2'd1, 10'h045);
        step(10'h040, 8'h48, 8'h00, 1'b0, "R4 read address nack");
        do_stop();

        // stuck SDA and recovery through the overrides
        stuck_arm = 1'b1;
        wr(2'd0, 10'h060);
        repeat (300) @(negedge clk);
        chk(status_rd == 8'hF8 && !ctl_rd[3], "R9 start waits on low SDA",
            {23'h0, ctl_rd[3], status_rd}, 32'hF8);
        chk(!scl_oe && !sda_oe, "R9 no line pulled while waiting", {30'h0, scl_oe, sda_oe}, 0);
        wr(2'd0, 10'h040);
        wr(2'd2, 10'h200);
        chk(scl_oe && !scl_line && !sda_oe, "R11 SCL override", {29'h0, scl_oe, scl_line, sda_oe}, 32'h4);
        for (int i = 0; i < 9; i++) begin
            wr(2'd2, 10'h000);
            repeat (4) @(negedge clk);
            wr(2'd2, 10'h200);
            repeat (4) @(negedge clk);
        end
        chk(sda_line == 1'b1, "R11 device freed by pulses", {31'h0, sda_line}, 1);
        wr(2'd2, 10'h300);
        wr(2'd2, 10'h100);
        chk(sda_oe && !scl_oe, "R11 SDA override", {30'h0, sda_oe, scl_oe}, 32'h2);
        wr(2'd2, 10'h000);
        chk(sda_line && scl_line, "R11 lines back to engine", {30'h0, sda_line, scl_line}, 32'h3);
        step(10'h060, 8'h08, 8'h00, 1'b0, "R9 start after release");
        do_stop();

        chk(exq.size() == 0, "R3 all events seen", exq.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule